// File: doc/BRIEF.md
# Sliding Register Window File

This block holds a bank of general-purpose registers of which only a fixed-size slice, the window, is addressable at any moment. Software names registers by a small logical number counted from the start of the current window. The block turns that logical number into a physical slot by adding a window base that moves on every subroutine call and return. It serves two reads and one write per cycle.

A call moves the base forward by half a window. The upper half of the caller's window therefore becomes the lower half of the callee's window, and arguments and results cross the call boundary without being copied. A return moves the base back by the same step. Slots outside the visible window keep their contents, so a caller gets back exactly the private values it left behind. A call with no free window raises an overflow flag, and a return from the outermost window raises an underflow flag. In both cases the base does not move. Spilling registers to memory is left to the surrounding logic.

Top module: `win_regfile`

## Requirements
- R1: After reset the window base is 0 and every logical register reads 0.
- R2: Physical slot = base × 4 + logical index (logical 0..7, base 0..2). Both read ports return that slot's content combinationally, from the current base.
- R3: A write with `wr_en_i` high stores `wr_data_i` into the slot mapped from `wr_idx_i` at the clock edge. The value reads back from the next cycle on.
- R4: A call (`call_i`=1, `ret_i`=0) with base below 2 raises the base by one at the edge. The caller's logical 4..7 then read as the callee's logical 0..3.
- R5: A return (`ret_i`=1, `call_i`=0) with base above 0 lowers the base by one at the edge. The caller's logical 0..3 then hold the values they had before the call.
- R6: A call while the base is 2 drives `ovf_o` high in that same cycle and leaves the base unchanged.
- R7: A return while the base is 0 drives `unf_o` high in that same cycle and leaves the base unchanged.
- R8: A write in the same cycle as a call or return uses the mapping of the base in force before that edge.
- R9: When `call_i` and `ret_i` are both high, the base does not change and neither flag rises.
- R10: A write changes only the one slot it maps to. All other slots, visible or not, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Slide the window forward one step |
| ret_i | input | 1 | Slide the window back one step |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 3 | Logical write index |
| wr_data_i | input | 32 | Write data |
| rd_a_idx_i | input | 3 | Logical index, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_idx_i | input | 3 | Logical index, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| base_o | output | 2 | Current window base |
| ovf_o | output | 1 | Call refused: no free window |
| unf_o | output | 1 | Return refused: already outermost |

## Verification
The hardest case to reach is a private value of an outer window that must survive a long nest of calls. In that case callee writes land on overlapping slots, and a deeper window must not disturb slots it cannot see. Weighted random calls, returns and writes drive the base through every level many times, and a bench model of all sixteen slots is compared with every read. Directed sequences hit the saturation edges, a write paired with a call, and a call paired with a return.

// File: rtl/win_pkg.sv
package win_pkg;

   typedef enum logic [1:0] {
      WIN_HOLD    = 2'd0,
      WIN_ADVANCE = 2'd1,
      WIN_RETREAT = 2'd2
   } win_move_e;

   function automatic win_move_e win_decide(input logic fwd, input logic back,
                                             input logic at_top, input logic at_bottom);
      win_move_e m;
      m = WIN_HOLD;
      if (fwd && !back && !at_top)
         m = WIN_ADVANCE;
      else if (back && !fwd && !at_bottom)
         m = WIN_RETREAT;
      return m;
   endfunction

endpackage

// File: rtl/win_base_ctrl.sv
module win_base_ctrl #(
   parameter int MAX_BASE = 2,
   parameter int BASE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              ret_i,
   output logic [BASE_W-1:0] base_o,
   output logic              ovf_o,
   output logic              unf_o
);
   import win_pkg::*;

   localparam logic [BASE_W-1:0] TOP_BASE = BASE_W'(MAX_BASE);

   logic [BASE_W-1:0] base_q;
   logic              at_top;
   logic              at_bottom;
   win_move_e         move;

   assign at_top    = (base_q == TOP_BASE);
   assign at_bottom = (base_q == '0);
   assign move      = win_decide(call_i, ret_i, at_top, at_bottom);

   assign ovf_o = call_i && !ret_i && at_top;
   assign unf_o = ret_i && !call_i && at_bottom;

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else begin
         case (move)
            WIN_ADVANCE: base_q <= base_q + 1'b1;
            WIN_RETREAT: base_q <= base_q - 1'b1;
            default:     base_q <= base_q;
         endcase
      end
   end

   assign base_o = base_q;
endmodule

// File: rtl/win_index_map.sv
module win_index_map #(
   parameter int SHIFT  = 4,
   parameter int LIDX_W = 3,
   parameter int PIDX_W = 4,
   parameter int BASE_W = 2
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [LIDX_W-1:0] lidx_i,
   output logic [PIDX_W-1:0] pidx_o
);
   localparam int  SHIFT_LOG = (SHIFT > 1) ? $clog2(SHIFT) : 0;
   localparam bit  SHIFT_POW2 = ((1 << SHIFT_LOG) == SHIFT);

   generate
      if (SHIFT_POW2) begin : g_shift
         assign pidx_o = (PIDX_W'(base_i) << SHIFT_LOG) + PIDX_W'(lidx_i);
      end else begin : g_mult
         assign pidx_o = PIDX_W'(base_i) * PIDX_W'(SHIFT) + PIDX_W'(lidx_i);
      end
   endgenerate
endmodule

// File: rtl/win_reg_array.sv
module win_reg_array #(
   parameter int NUM_PHYS = 16,
   parameter int DATA_W   = 32,
   parameter int PIDX_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [PIDX_W-1:0] wr_pidx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PIDX_W-1:0] rd_a_pidx_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   input  logic [PIDX_W-1:0] rd_b_pidx_i,
   output logic [DATA_W-1:0] rd_b_data_o
);
   logic [DATA_W-1:0] slot_q [NUM_PHYS];

   generate
      for (genvar s = 0; s < NUM_PHYS; s++) begin : g_slot
         logic hit;
         assign hit = we_i && (wr_pidx_i == PIDX_W'(s));
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q[s] <= '0;
            else if (hit)
               slot_q[s] <= wr_data_i;
         end
      end
   endgenerate

   always_comb begin
      rd_a_data_o = '0;
      rd_b_data_o = '0;
      for (int s = 0; s < NUM_PHYS; s++) begin
         if (rd_a_pidx_i == PIDX_W'(s)) rd_a_data_o = slot_q[s];
         if (rd_b_pidx_i == PIDX_W'(s)) rd_b_data_o = slot_q[s];
      end
   end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
   parameter int NUM_PHYS = 16,
   parameter int WIN_SIZE = 8,
   parameter int SHIFT    = 4,
   parameter int DATA_W   = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        call_i,
   input  logic                        ret_i,
   input  logic                        wr_en_i,
   input  logic [$clog2(WIN_SIZE)-1:0] wr_idx_i,
   input  logic [DATA_W-1:0]           wr_data_i,
   input  logic [$clog2(WIN_SIZE)-1:0] rd_a_idx_i,
   output logic [DATA_W-1:0]           rd_a_data_o,
   input  logic [$clog2(WIN_SIZE)-1:0] rd_b_idx_i,
   output logic [DATA_W-1:0]           rd_b_data_o,
   output logic [$clog2((NUM_PHYS-WIN_SIZE)/SHIFT+1)-1:0] base_o,
   output logic                        ovf_o,
   output logic                        unf_o
);
   localparam int LIDX_W   = $clog2(WIN_SIZE);
   localparam int PIDX_W   = $clog2(NUM_PHYS);
   localparam int MAX_BASE = (NUM_PHYS - WIN_SIZE) / SHIFT;
   localparam int BASE_W   = $clog2(MAX_BASE + 1);
   localparam int NPORT    = 3;

   generate
      if ((NUM_PHYS - WIN_SIZE) % SHIFT != 0) begin : g_chk_step
         $error("window step must divide the spare slot count");
      end
      if (SHIFT < 1 || SHIFT > WIN_SIZE) begin : g_chk_shift
         $error("window step must lie between 1 and the window size");
      end
      if (NUM_PHYS <= WIN_SIZE) begin : g_chk_depth
         $error("slot count must exceed the window size");
      end
      if ((1 << LIDX_W) != WIN_SIZE) begin : g_chk_pow2
         $error("window size must be a power of two");
      end
   endgenerate

   logic [BASE_W-1:0] base;
   logic [LIDX_W-1:0] lidx [NPORT];
   logic [PIDX_W-1:0] pidx [NPORT];

   assign lidx[0] = wr_idx_i;
   assign lidx[1] = rd_a_idx_i;
   assign lidx[2] = rd_b_idx_i;

   win_base_ctrl #(
      .MAX_BASE (MAX_BASE),
      .BASE_W   (BASE_W)
   ) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .call_i (call_i),
      .ret_i  (ret_i),
      .base_o (base),
      .ovf_o  (ovf_o),
      .unf_o  (unf_o)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_map
         win_index_map #(
            .SHIFT  (SHIFT),
            .LIDX_W (LIDX_W),
            .PIDX_W (PIDX_W),
            .BASE_W (BASE_W)
         ) u_map (
            .base_i (base),
            .lidx_i (lidx[p]),
            .pidx_o (pidx[p])
         );
      end
   endgenerate

   win_reg_array #(
      .NUM_PHYS (NUM_PHYS),
      .DATA_W   (DATA_W),
      .PIDX_W   (PIDX_W)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (wr_en_i),
      .wr_pidx_i   (pidx[0]),
      .wr_data_i   (wr_data_i),
      .rd_a_pidx_i (pidx[1]),
      .rd_a_data_o (rd_a_data_o),
      .rd_b_pidx_i (pidx[2]),
      .rd_b_data_o (rd_b_data_o)
   );

   assign base_o = base;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
   parameter int BASE_W   = 2,
   parameter int MAX_BASE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              ret_i,
   input logic [BASE_W-1:0] base_o,
   input logic              ovf_o,
   input logic              unf_o
);
   assert_base_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      base_o <= BASE_W'(MAX_BASE));

   assert_call_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && !ovf_o) |=> (base_o == $past(base_o) + 1'b1));

   assert_ret_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && !unf_o) |=> (base_o == $past(base_o) - 1'b1));

   assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> $stable(base_o));

   assert_no_underflow_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> $stable(base_o));

   assert_both_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i) |=> $stable(base_o));

   assert_both_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i) |-> !(ovf_o || unf_o));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_i && !ret_i) |=> $stable(base_o));
endmodule

bind win_regfile win_regfile_chk #(
   .BASE_W   (BASE_W),
   .MAX_BASE (MAX_BASE)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .call_i (call_i),
   .ret_i  (ret_i),
   .base_o (base_o),
   .ovf_o  (ovf_o),
   .unf_o  (unf_o)
);

// File: tb/tb_win_regfile.sv
module tb_win_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        call_i, ret_i, wr_en_i;
   logic [2:0]  wr_idx_i, rd_a_idx_i, rd_b_idx_i;
   logic [31:0] wr_data_i, rd_a_data_o, rd_b_data_o;
   logic [1:0]  base_o;
   logic        ovf_o, unf_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [31:0] mdl [16];
   int          mbase;

   always #10 clk = ~clk;

   win_regfile dut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
      .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
      .base_o(base_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   function automatic logic [31:0] exp_rd(input int b, input logic [2:0] l);
      return mdl[b*4 + int'(l)];
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit c, input bit r, input bit we,
                       input logic [2:0] wi, input logic [31:0] wd,
                       input logic [2:0] ra, input logic [2:0] rb);
      bit e_ovf, e_unf;
      @(negedge clk);
      call_i = c; ret_i = r; wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
      rd_a_idx_i = ra; rd_b_idx_i = rb;
      #1;
      e_ovf = c && !r && (mbase == 2);
      e_unf = r && !c && (mbase == 0);
      chk(tag, "base", 32'(base_o), 32'(mbase));
      chk(tag, "ovf", 32'(ovf_o), 32'(e_ovf));
      chk(tag, "unf", 32'(unf_o), 32'(e_unf));
      chk(tag, "rd_a", rd_a_data_o, exp_rd(mbase, ra));
      chk(tag, "rd_b", rd_b_data_o, exp_rd(mbase, rb));
      @(posedge clk);
      if (we) mdl[mbase*4 + int'(wi)] = wd;
      if (c && !r && mbase < 2) mbase++;
      else if (r && !c && mbase > 0) mbase--;
   endtask

   task automatic wr(input string tag, input logic [2:0] wi, input logic [31:0] wd);
      step(tag, 0, 0, 1, wi, wd, wi, 3'(wi + 1));
   endtask

   task automatic rd_check(input string tag, input logic [2:0] l, input logic [31:0] exp);
      @(negedge clk);
      call_i = 0; ret_i = 0; wr_en_i = 0; rd_a_idx_i = l; rd_b_idx_i = l;
      #1;
      chk(tag, "direct", rd_a_data_o, exp);
   endtask

   task automatic sweep(input string tag);
      for (int l = 0; l < 8; l += 2) step(tag, 0, 0, 0, 3'd0, 32'd0, 3'(l), 3'(l + 1));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int unused_seed;
      unused_seed = $urandom(32'd1234);
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      mbase = 0;
      rst_n = 0; call_i = 0; ret_i = 0; wr_en_i = 0;
      wr_idx_i = 0; wr_data_i = 0; rd_a_idx_i = 0; rd_b_idx_i = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: reset state
      sweep("R1");

      // R2 / R3: write all logical registers of window 0, read back
      for (int l = 0; l < 8; l++) wr("R3", 3'(l), 32'hA000_0000 + 32'(l));
      sweep("R2");

      // R4: caller 4..7 appear as callee 0..3
      step("R4", 1, 0, 0, 0, 0, 0, 1);
      for (int l = 0; l < 4; l++) rd_check("R4", 3'(l), 32'hA000_0004 + 32'(l));

      // callee overwrites its whole window
      for (int l = 0; l < 8; l++) wr("R10", 3'(l), 32'hB000_0000 + 32'(l));

      // R6: climb to top, then overflow
      step("R4", 1, 0, 0, 0, 0, 0, 0);
      step("R6", 1, 0, 0, 0, 0, 0, 0);
      chk("R6", "base held", 32'(base_o), 32'd2);

      // R9: simultaneous call and return at top and middle
      step("R9", 1, 1, 0, 0, 0, 2, 3);
      chk("R9", "base", 32'(base_o), 32'd2);

      // R5: back to window 0, caller private regs restored
      step("R5", 0, 1, 0, 0, 0, 0, 0);
      step("R5", 0, 1, 0, 0, 0, 0, 0);
      for (int l = 0; l < 4; l++) rd_check("R5", 3'(l), 32'hA000_0000 + 32'(l));

      // R7: underflow at base 0
      step("R7", 0, 1, 0, 0, 0, 0, 0);
      chk("R7", "base held", 32'(base_o), 32'd0);

      // R8: write paired with call uses old base (phys 5 -> callee logical 1)
      step("R8", 1, 0, 1, 3'd5, 32'hC0DE_0005, 0, 0);
      rd_check("R8", 3'd1, 32'hC0DE_0005);
      // write paired with return uses old base (base1 logical 2 -> phys 6)
      step("R8", 0, 1, 1, 3'd2, 32'hC0DE_0006, 0, 0);
      rd_check("R8", 3'd6, 32'hC0DE_0006);

      // random phase, weighted toward writes
      for (int n = 0; n < 4000; n++) begin
         int sel;
         bit c, r, we;
         sel = int'($urandom_range(0, 99));
         c  = (sel < 20) || (sel >= 95);
         r  = (sel >= 20 && sel < 40) || (sel >= 95);
         we = (sel >= 30);
         v  = $urandom;
         step("R10", c, r, we, 3'($urandom_range(0, 7)), v,
              3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
      end

      // final sweep of every window
      while (mbase > 0) step("R5", 0, 1, 0, 0, 0, 0, 0);
      sweep("R10");
      step("R4", 1, 0, 0, 0, 0, 0, 0);
      sweep("R10");
      step("R4", 1, 0, 0, 0, 0, 0, 0);
      sweep("R10");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule